// File: doc/BRIEF.md
# Binary-Field Mixed-Coordinate Point Adder

This block adds two points of an elliptic curve y² + xy = x³ + a·x² + b defined over GF(2^8). One addend arrives in projective form (X1, Y1, Z1) and the other in affine form (x2, y2). The sum leaves in projective form (X3, Y3, Z3). Because the result stays projective, the block never needs a field inversion. It is intended as the addition kernel inside a larger scalar-multiplication sequencer, which converts results back to affine form elsewhere.

All field products go through a single combinational GF(2^8) multiplier. A step controller walks fourteen fixed steps, one product per clock, and keeps the intermediates in a small set of registers. A one-cycle start pulse captures both points and the curve constant a. A one-cycle done pulse marks the moment the three result words become valid. The result words then hold their values until the next operation completes.

Top module: `gf2m_mixed_padd`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, done_o is 0 and rx_o, ry_o and rz_o are all 0.
- R2: Field elements are 8-bit polynomials over GF(2). Bit i is the coefficient of x^i. Addition is bitwise XOR. Products are reduced modulo x^8 + x^4 + x^3 + x + 1 (0x11B).
- R3: rz_o equals C², where B = X1 + x2·Z1 and C = B·Z1.
- R4: rx_o equals A² + C·E, where A = Y1 + y2·Z1² and E = A + B² + a·C.
- R5: ry_o equals (x2·Z3 + X3)·(A·C + Z3) + (x2 + y2)·Z3², using the Z3 and X3 of R3 and R4.
- R6: A start is accepted on a rising clock edge at which start is 1 and no operation is in progress. done_o is then 1 for exactly one cycle: the cycle that follows the 14th rising edge after the accepting edge.
- R7: A start that arrives while an operation is in progress is ignored. It produces no extra done pulse and does not alter the result of the running operation.
- R8: Operands are captured at the accepting edge. Changes on the operand inputs during an operation do not affect its result.
- R9: start is accepted in the same cycle in which done_o is 1, so operations can run back to back every 15 cycles.
- R10: rx_o, ry_o and rz_o change only at the edge that raises done_o. At all other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an addition |
| px_i | input | 8 | Projective X1 |
| py_i | input | 8 | Projective Y1 |
| pz_i | input | 8 | Projective Z1 |
| ax_i | input | 8 | Affine x2 |
| ay_i | input | 8 | Affine y2 |
| curve_a_i | input | 8 | Curve constant a |
| rx_o | output | 8 | Result X3 |
| ry_o | output | 8 | Result Y3 |
| rz_o | output | 8 | Result Z3 |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
Completion of one operation (the done pulse and the loading of the result words) can fall in the same cycle as the acceptance of the next start. The bench provokes this by holding start high for long stretches while the operand inputs change every cycle. A correct design must then restart exactly on the done cycle and ignore every earlier request. A behavioural reference tracks the accepted starts cycle by cycle, computes the expected sums with its own multiply-then-reduce routine, and compares done_o and the three result words after every clock. Random start densities around this overlap supply further cases, including a = 0, Z1 = 1 and zero operands.

// File: rtl/padd_pkg.sv
`timescale 1ns/1ps
package padd_pkg;
  typedef enum logic [3:0] {
    ST_ZSQ, ST_A, ST_B, ST_C, ST_Z3, ST_BSQ, ST_E,
    ST_ASQ, ST_X3, ST_D, ST_J, ST_F, ST_K, ST_Y3
  } step_e;
  localparam int NSTEPS = 14;
  localparam step_e LAST_STEP = ST_Y3;
endpackage

// File: rtl/gf_mult.sv
`timescale 1ns/1ps
module gf_mult #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 8'h1B
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod
);
  // Horner-form product: shift accumulator, fold top bit with POLY (R2)
  function automatic logic [W-1:0] gmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] acc;
    acc = '0;
    for (int i = W - 1; i >= 0; i--) begin
      acc = {acc[W-2:0], 1'b0} ^ (acc[W-1] ? POLY : '0);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  assign prod = gmul(op_a, op_b);
endmodule

// File: rtl/padd_ctrl.sv
`timescale 1ns/1ps
module padd_ctrl
  import padd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output logic  accept,
  output logic  busy,
  output step_e step,
  output logic  last,
  output logic  done
);
  assign accept = start && !busy;
  assign last   = busy && (step == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= ST_ZSQ;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1;
        step <= ST_ZSQ;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      step <= step_e'(step + 4'd1);
      end
    end
  end

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6: final step is followed by done
  a_r6_last_done: assert property (@(posedge clk) disable iff (!rst_n) last |=> done);
  // R7: a running sequence keeps stepping whatever start does
  a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && (step == step_e'($past(step) + 4'd1))));
  // R9: start in the done cycle begins a new run
  a_r9_accept_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (busy && step == ST_ZSQ));
endmodule

// File: rtl/gf2m_mixed_padd.sv
`timescale 1ns/1ps
module gf2m_mixed_padd
  import padd_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 8'h1B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] px_i,
  input  logic [W-1:0] py_i,
  input  logic [W-1:0] pz_i,
  input  logic [W-1:0] ax_i,
  input  logic [W-1:0] ay_i,
  input  logic [W-1:0] curve_a_i,
  output logic [W-1:0] rx_o,
  output logic [W-1:0] ry_o,
  output logic [W-1:0] rz_o,
  output logic         done_o
);
  logic  accept, busy, last;
  step_e step;
  logic [W-1:0] op_a, op_b, addend, prod, res;

  // captured operands
  logic [W-1:0] cX1, cY1, cZ1, cx2, cy2, ca;
  // intermediates
  logic [W-1:0] tZsq, tA, tB, tC, tZ3, tBsq, tE, tAsq, tX3, tD, tJ, tF, tK;

  padd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .busy(busy), .step(step), .last(last), .done(done_o)
  );

  gf_mult #(.W(W), .POLY(POLY)) u_mul (.op_a(op_a), .op_b(op_b), .prod(prod));

  // operand routing per step: res = op_a*op_b + addend
  always_comb begin
    op_a = '0; op_b = '0; addend = '0;
    unique case (step)
      ST_ZSQ: begin op_a = cZ1;       op_b = cZ1; end
      ST_A:   begin op_a = cy2;       op_b = tZsq; addend = cY1; end
      ST_B:   begin op_a = cx2;       op_b = cZ1;  addend = cX1; end
      ST_C:   begin op_a = tB;        op_b = cZ1; end
      ST_Z3:  begin op_a = tC;        op_b = tC; end
      ST_BSQ: begin op_a = tB;        op_b = tB; end
      ST_E:   begin op_a = ca;        op_b = tC;   addend = tA ^ tBsq; end
      ST_ASQ: begin op_a = tA;        op_b = tA; end
      ST_X3:  begin op_a = tC;        op_b = tE;   addend = tAsq; end
      ST_D:   begin op_a = cx2;       op_b = tZ3; end
      ST_J:   begin op_a = tA;        op_b = tC;   addend = tZ3; end
      ST_F:   begin op_a = tD ^ tX3;  op_b = tJ; end
      ST_K:   begin op_a = tZ3;       op_b = tZ3; end
      ST_Y3:  begin op_a = cx2 ^ cy2; op_b = tK;   addend = tF; end
      default: ;
    endcase
  end
  assign res = prod ^ addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cX1, cY1, cZ1, cx2, cy2, ca} <= '0;
      {tZsq, tA, tB, tC, tZ3, tBsq, tE} <= '0;
      {tAsq, tX3, tD, tJ, tF, tK} <= '0;
      rx_o <= '0; ry_o <= '0; rz_o <= '0;
    end else if (accept) begin
      cX1 <= px_i; cY1 <= py_i; cZ1 <= pz_i;
      cx2 <= ax_i; cy2 <= ay_i; ca <= curve_a_i;
    end else if (busy) begin
      unique case (step)
        ST_ZSQ: tZsq <= res;
        ST_A:   tA   <= res;
        ST_B:   tB   <= res;
        ST_C:   tC   <= res;
        ST_Z3:  tZ3  <= res;
        ST_BSQ: tBsq <= res;
        ST_E:   tE   <= res;
        ST_ASQ: tAsq <= res;
        ST_X3:  tX3  <= res;
        ST_D:   tD   <= res;
        ST_J:   tJ   <= res;
        ST_F:   tF   <= res;
        ST_K:   tK   <= res;
        ST_Y3: begin
          rx_o <= tX3;
          rz_o <= tZ3;
          ry_o <= res;
        end
        default: ;
      endcase
    end
  end

  // R10: results move only when the last step retires
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> ($stable(rx_o) && $stable(ry_o) && $stable(rz_o)));
  // R8: captured operands stay fixed during a run
  a_r8_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> ($stable(cX1) && $stable(cZ1) && $stable(cx2) && $stable(cy2)));
endmodule

// File: tb/gf2m_mixed_padd_bench.sv
`timescale 1ns/1ps
module gf2m_mixed_padd_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] px = '0, py = '0, pz = '0, ax = '0, ay = '0, ca = '0;
  logic [7:0] rx, ry, rz;
  logic done;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  gf2m_mixed_padd u_gf2m_mixed_padd (
    .clk(clk), .rst_n(rst_n), .start(start),
    .px_i(px), .py_i(py), .pz_i(pz), .ax_i(ax), .ay_i(ay), .curve_a_i(ca),
    .rx_o(rx), .ry_o(ry), .rz_o(rz), .done_o(done)
  );

  // R2: carry-less product in 16 bits, then fold with 0x11B
  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11B << (i - 8));
    return p[7:0];
  endfunction

  task automatic ref_add(input logic [7:0] X1, Y1, Z1, x2, y2, a,
                         output logic [7:0] X3, Y3, Z3);
    logic [7:0] A, B, C, E, D, J, F, K;
    A  = Y1 ^ fmul(y2, fmul(Z1, Z1));
    B  = X1 ^ fmul(x2, Z1);
    C  = fmul(B, Z1);
    Z3 = fmul(C, C);                       // R3
    E  = A ^ fmul(B, B) ^ fmul(a, C);
    X3 = fmul(A, A) ^ fmul(C, E);          // R4
    D  = fmul(x2, Z3);
    J  = fmul(A, C) ^ Z3;
    F  = fmul(D ^ X3, J);
    K  = fmul(Z3, Z3);
    Y3 = F ^ fmul(x2 ^ y2, K);             // R5
  endtask

  // cycle-level reference: a run lasts 14 edges after acceptance (R6, R7, R9)
  int remaining = 0;
  logic exp_done = 1'b0;
  logic [7:0] pend_x = '0, pend_y = '0, pend_z = '0;
  logic [7:0] exp_x = '0, exp_y = '0, exp_z = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining = 0; exp_done = 1'b0;
      exp_x = '0; exp_y = '0; exp_z = '0;
    end else begin
      exp_done = (remaining == 1);
      if (remaining > 0) begin
        remaining = remaining - 1;
        if (remaining == 0) begin exp_x = pend_x; exp_y = pend_y; exp_z = pend_z; end
      end else if (start) begin
        remaining = 14;
        ref_add(px, py, pz, ax, ay, ca, pend_x, pend_y, pend_z);  // R8: sampled here only
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    vectors++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      check("R6/R7/R9 done", {7'd0, done}, {7'd0, exp_done});
      if (exp_done) begin
        check("R3 Z3", rz, exp_z);
        check("R4 X3", rx, exp_x);
        check("R5 Y3", ry, exp_y);
      end else begin
        check("R10 hold X", rx, exp_x);
        check("R10 hold Y", ry, exp_y);
        check("R10 hold Z", rz, exp_z);
      end
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic set_ops(input logic [7:0] X1, Y1, Z1, x2, y2, a);
    px = X1; py = Y1; pz = Z1; ax = x2; ay = y2; ca = a;
  endtask

  task automatic rnd_ops();
    set_ops(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 done", {7'd0, done}, 8'd0);
    check("R1 X", rx, 8'd0);
    check("R1 Y", ry, 8'd0);
    check("R1 Z", rz, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // single operations with fixed operands (a=0, Z1=1, zeros)
    set_ops(8'h57, 8'h83, 8'h01, 8'h13, 8'hC4, 8'h00); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    set_ops(8'hA5, 8'h3C, 8'h9E, 8'hFF, 8'h01, 8'h01); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R7, R8: stray starts and operand churn mid-run
    repeat (5) @(negedge clk);
    start = 1'b1; rnd_ops();
    @(negedge clk); start = 1'b0; rnd_ops();
    repeat (12) @(negedge clk);
    set_ops(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (18) @(negedge clk);

    // R9: start held high, operands changing every cycle -> back-to-back runs
    start = 1'b1;
    for (int i = 0; i < 150; i++) begin rnd_ops(); @(negedge clk); end
    start = 1'b0;
    repeat (20) @(negedge clk);

    // mixed density
    for (int i = 0; i < 3000; i++) begin
      start = ($urandom % 3) == 0;
      rnd_ops();
      @(negedge clk);
    end
    start = 1'b0;
    repeat (20) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule